// File: doc/BRIEF.md
# Serial Two-Wire Register Slave with Wrapping Pointer

This block is a two-wire (I2C) bus slave that lives inside a synchronous design. It samples the bus clock and data lines through synchronizers on the system clock and detects START, repeated START and STOP. It matches a 7-bit device address, one bit of which comes from a strap input. It then moves bytes between the bus and a 17-entry register space, located at 00h through 10h, through a pointer that advances by itself.

The register storage sits outside the block. The slave presents a register address and gives a one-cycle write strobe with the received byte. For reads it gives a one-cycle read strobe and takes the byte combinationally from the register file in the same cycle. The slave also pulses a snapshot output so that an external counter can copy its running value into a holding register. The pulse follows each START and each pointer wrap to 00h. The slave only ever pulls the data line low; an external pull-up supplies the high level.

A watchdog on the bus clock returns the slave to idle if SCL stays low for too long. When that happens the slave lets go of SDA and waits for a fresh START.

Top module: `i2c_regptr_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its top seven bits equal 110100 followed by the level of `addr_sel`; bit 0 of that byte selects read (1) or write (0). A byte with any other address gets no acknowledge, and the slave drives nothing until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer. Each later byte is written at the pointer, is acknowledged, and moves the pointer forward by one.
- R3: A read transfer returns bytes starting at the current pointer, whether the pointer was just written or was left by an earlier transfer. The pointer moves forward by one for every byte fetched.
- R4: The pointer goes from 10h to 00h. A pointer byte greater than 10h loads 00h.
- R5: `snapshot` pulses for one cycle after every START, repeated START included, and after every pointer step from 10h to 00h.
- R6: A not-acknowledge from the master after a read byte ends the transfer. The slave releases SDA and does not pull it again before the next START.
- R7: If the synchronized SCL stays low for `TMO_CYCLES` system clocks, the slave returns to idle and releases SDA. A low period that is clearly shorter leaves a transfer in progress untouched.
- R8: Addresses 09h to 10h are read-only identity bytes. A byte written there is acknowledged and moves the pointer, but gives no write strobe.
- R9: The slave changes its SDA drive only while SCL is low. A STOP returns the slave to idle.
- R10: After reset the slave does not drive SDA and gives no strobe and no snapshot pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 1 | Strap level for the lowest address bit |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | PW | Current register pointer |
| reg_wr | output | 1 | One-cycle write strobe at `reg_addr` |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | One-cycle fetch strobe at `reg_addr` |
| reg_rdata | input | 8 | Register byte at `reg_addr`, combinational |
| snapshot | output | 1 | One-cycle pulse to latch the counters |

## Verification
Two events can land on the same clock edge. When the byte at 10h is fetched or written, the pointer wraps and raises a snapshot pulse in the same cycle as the read or write strobe for that byte. The bench provokes this by writing seventeen bytes from 00h and by reading eighteen bytes across the wrap. It judges the outcome in three ways: it counts the snapshot pulses in each transfer against one per START plus one per wrap, it checks that the byte after 10h is the one at 00h, and it counts the write strobes that reach the writable range.

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave #(
  parameter logic [5:0] ADDR_HI    = 6'b110100,
  parameter int         LAST_REG   = 16,
  parameter int         ID_BASE    = 9,
  parameter int         PW         = $clog2(LAST_REG + 1),
  parameter int         TMO_CYCLES = 3_500_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          addr_sel,
  output logic          sda_pull,
  output logic [PW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata,
  output logic          snapshot
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [PW-1:0] LAST_P = PW'(LAST_REG);
  localparam logic [PW-1:0] ID_P   = PW'(ID_BASE);
  localparam logic [7:0]    LAST_B = 8'(LAST_REG);
  localparam logic [TW-1:0] TMO_LIM = TW'(TMO_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WRX, S_SACK, S_TX, S_MACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_c, stop_c;
  st_t st;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic rw, got_ptr, ack_on;
  logic [PW-1:0] ptr, ptr_next;
  logic [TW-1:0] tmo_cnt;
  logic tmo_hit;
  logic [7:0] byte_in;
  logic byte_done, wr_byte, adv, ptr_wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  assign byte_in   = {sh, sda_s};
  assign byte_done = scl_rise & (bcnt == 3'd7);
  assign wr_byte   = (st == S_WRX) & byte_done & got_ptr;
  assign reg_wr    = wr_byte & (ptr < ID_P);
  assign reg_wdata = byte_in;
  assign reg_rd    = scl_fall & ack_on & (((st == S_SACK) & rw) | (st == S_MACK));
  assign reg_addr  = ptr;
  assign adv       = wr_byte | reg_rd;
  assign ptr_wrap  = adv & (ptr == LAST_P);
  assign ptr_next  = ptr_wrap ? '0 : ptr + PW'(1);
  assign tmo_hit   = ~scl_s & (tmo_cnt == TMO_LIM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmo_cnt <= '0;
    else if (scl_s) tmo_cnt <= '0;
    else if (!tmo_hit) tmo_cnt <= tmo_cnt + TW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; rw <= 1'b0; got_ptr <= 1'b0;
      ack_on <= 1'b0; sda_pull <= 1'b0; ptr <= '0; snapshot <= 1'b0;
    end else begin
      snapshot <= start_c | ptr_wrap;
      if (adv) ptr <= ptr_next;
      if (tmo_hit) begin
        st <= S_IDLE; sda_pull <= 1'b0; ack_on <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; bcnt <= '0; sda_pull <= 1'b0; ack_on <= 1'b0; got_ptr <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_pull <= 1'b0; ack_on <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WRX: if (scl_rise) begin
            sh   <= byte_in[6:0];
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (st == S_ADDR) begin
                if (byte_in[7:1] == {ADDR_HI, addr_sel}) begin
                  rw <= byte_in[0];
                  st <= S_SACK;
                end else st <= S_IDLE;
              end else begin
                if (!got_ptr) ptr <= (byte_in > LAST_B) ? '0 : byte_in[PW-1:0];
                got_ptr <= 1'b1;
                st <= S_SACK;
              end
            end
          end
          S_SACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1; sda_pull <= 1'b1;
            end else begin
              ack_on <= 1'b0; bcnt <= '0;
              if (rw) begin
                sh <= reg_rdata[6:0]; sda_pull <= ~reg_rdata[7]; st <= S_TX;
              end else begin
                sda_pull <= 1'b0; st <= S_WRX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) st <= S_MACK;
            end
            if (scl_fall) begin
              sh <= {sh[5:0], 1'b0}; sda_pull <= ~sh[6];
            end
          end
          S_MACK: begin
            if (scl_fall) begin
              if (!ack_on) sda_pull <= 1'b0;
              else begin
                ack_on <= 1'b0; bcnt <= '0;
                sh <= reg_rdata[6:0]; sda_pull <= ~reg_rdata[7]; st <= S_TX;
              end
            end
            if (scl_rise) begin
              if (sda_s) st <= S_IDLE;
              else ack_on <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

  a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_q);
  a_r5_snap_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> snapshot);
  a_r8_no_id_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr < ID_P));
  a_r4_ptr_in_space: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST_P);
  a_r7_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!sda_pull && st == S_IDLE));
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull);
  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: tb/i2c_regptr_slave_tb.sv
module i2c_regptr_slave_tb_top;
  localparam int Q = 4;
  localparam int TMO = 300;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic sda_line, sda_pull, reg_wr, reg_rd, snapshot;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [0:16];
  int vec = 0, errs = 0, snap_cnt = 0, wr_cnt = 0, pull_cyc = 0, viol = 0;
  logic pull_d = 1'b0;

  assign sda_line = sda_m & ~sda_pull;
  assign reg_rdata = (reg_addr <= 5'd16) ? regs[reg_addr] : 8'h00;

  i2c_regptr_slave #(.TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .addr_sel(sel),
    .sda_pull(sda_pull), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .snapshot(snapshot));

  function automatic logic [7:0] idv(input int i); return 8'(8'hC0 + i); endfunction
  function automatic logic [7:0] wv(input int i);  return 8'(8'h3C ^ (i * 5)); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 17; i++) regs[i] <= (i >= 9) ? idv(i) : 8'h5A;
    end else if (reg_wr) regs[reg_addr] <= reg_wdata;
    if (snapshot) snap_cnt <= snap_cnt + 1;
    if (reg_wr) wr_cnt <= wr_cnt + 1;
    if (sda_pull) pull_cyc <= pull_cyc + 1;
    pull_d <= sda_pull;
    if (rst_n && scl_m && sda_pull != pull_d) viol <= viol + 1;
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart;
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic bstop;
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask
  task automatic put_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2 * Q); scl_m = 0; wq(Q);
    end
  endtask
  task automatic send(input logic [7:0] b, output logic ack);
    put_bits(b);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); ack = !sda_line; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic recv(output logic [7:0] b, input logic last);
    sda_m = 1; b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1; wq(Q); b = {b[6:0], sda_line}; wq(Q); scl_m = 0;
    end
    sda_m = last; wq(Q); scl_m = 1; wq(2 * Q); scl_m = 0; wq(Q); sda_m = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; vec++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    logic ack, ack2;
    logic [7:0] b;
    int s0, w0, p0;
    wq(5); rst_n = 1; wq(5);
    chk("R10 sda_pull", sda_pull, 0);
    chk("R10 snapshot", snapshot, 0);
    chk("R10 reg_wr", reg_wr, 0);

    // R1 address sweep over both strap levels, R5 start pulses
    s0 = snap_cnt;
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      for (int a = 0; a < 128; a++) begin
        bstart;
        send({7'(a), 1'b0}, ack);
        chk("R1 addr ack", ack, (a == (8'h68 | s)) ? 1 : 0);
        if (a != (8'h68 | s)) begin
          send(8'h00, ack2);
          chk("R1 ignored after mismatch", ack2, 0);
        end
        bstop;
      end
    end
    chk("R5 start pulses", snap_cnt - s0, 256);

    // R2/R8 write 17 bytes from 00h, wrapping
    sel = 1;
    s0 = snap_cnt; w0 = wr_cnt;
    bstart; send(8'hD2, ack); send(8'h00, ack);
    chk("R2 ptr ack", ack, 1);
    for (int i = 0; i < 17; i++) begin
      send(wv(i), ack);
      chk("R2 data ack", ack, 1);
    end
    bstop;
    chk("R8 strobes only below 09h", wr_cnt - w0, 9);
    chk("R5 start+wrap on write", snap_cnt - s0, 2);

    // R3/R4 pointer write then repeated-start read across the wrap
    s0 = snap_cnt;
    bstart; send(8'hD2, ack); send(8'h00, ack);
    bstart; send(8'hD3, ack);
    chk("R3 read addr ack", ack, 1);
    for (int i = 0; i < 18; i++) begin
      recv(b, i == 17);
      chk("R3 R4 read byte", b, ((i % 17) < 9) ? wv(i % 17) : idv(i % 17));
    end
    bstop;
    chk("R5 start+restart+wrap", snap_cnt - s0, 3);

    // R3 current-address read continues at 01h
    bstart; send(8'hD3, ack); recv(b, 1'b1); bstop;
    chk("R3 current address", b, wv(1));

    // R4 oversize pointer loads 00h
    bstart; send(8'hD2, ack); send(8'h25, ack); bstop;
    bstart; send(8'hD3, ack); recv(b, 1'b1); bstop;
    chk("R4 oversize pointer", b, wv(0));

    // R4 read from 10h then 00h; R6 silence after NACK
    bstart; send(8'hD2, ack); send(8'h10, ack);
    bstart; send(8'hD3, ack);
    recv(b, 1'b0); chk("R4 byte at 10h", b, idv(16));
    recv(b, 1'b1); chk("R4 byte after wrap", b, wv(0));
    p0 = pull_cyc;
    send(8'hFF, ack);
    chk("R6 no ack after NACK", ack, 0);
    chk("R6 no drive after NACK", pull_cyc - p0, 0);
    bstop;

    // R7 short low period keeps the acknowledge
    bstart; put_bits(8'hD2);
    chk("R7 ack driven", sda_pull, 1);
    wq(TMO - 60);
    chk("R7 short low no reset", sda_pull, 1);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    chk("R7 ack survives", sda_line, 0);
    wq(Q); scl_m = 0; wq(Q); bstop;

    // R7 long low period releases SDA
    bstart; put_bits(8'hD2);
    wq(TMO + 20);
    chk("R7 timeout release", sda_pull, 0);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    chk("R7 no ack after timeout", sda_line, 1);
    wq(Q); scl_m = 0; wq(Q); bstop;
    bstart; send(8'hD2, ack); bstop;
    chk("R7 new START accepted", ack, 1);

    // R9 idle after STOP, no drive change while SCL high
    chk("R9 idle after stop", sda_pull, 0);
    chk("R9 drive changes with SCL high", viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule